// File: doc/BRIEF.md
# Battery Charge Cycle Timer and Fault Controller

This block is the digital supervisor of a battery charger. It runs the charge-cycle timer from a slow enable tick. It decides whether the charger is conditioning a deeply discharged cell, charging normally, idling, finished, or halted by a fault. It then turns that decision into a charge enable, two open-drain status controls and a soft-start discharge request.

Every input is a one-bit comparator flag from the analog front end. The flags are:

- battery below the precondition threshold
- cell too hot and cell too cold, which set the temperature fault
- temperature back in window, which releases the temperature fault
- charge current below C/10
- die over-temperature
- shutdown
- termination-mode select

Comparator hysteresis lives outside the block. It reaches the block only as the separate set and release flags for temperature.

In timer-termination mode the block watches for dead cells. A cell that cannot leave precondition by one-eighth of the full timer cycle is declared bad. So is a cell that falls back into precondition after that point. A temperature fault freezes the timer and does not reset it. In C/10 mode there is no timer and no dead-cell check: a low charge current parks the charger in standby.

Top module: `chg_timer_ctrl`

## Requirements
- R1: While `shdn_i` is 1, every output is 0 and the timer is cleared. After `shdn_i` falls, a new cycle starts from a timer count of zero: precondition if `bat_low_i` is 1, normal charge otherwise.
- R2: In timer mode (`timer_mode_i`=1), the timer advances by one for each clock with `tick_i`=1, but only while precondition or normal charge is active. If `bat_low_i` is still 1 when the count reaches CYCLE_TICKS/8 (integer division, i.e. a right shift by three), the bad-battery fault is entered.
- R3: In timer mode, if `bat_low_i` rises during normal charge before the one-eighth point, the block returns to precondition and keeps charging. If it rises at or after that point, the bad-battery fault is entered.
- R4: During the bad-battery fault the outputs are `chg_en_o`=0, `chrg_low_o`=0 (released), `fault_low_o`=1 and `ss_dis_o`=1. The timer stays at zero.
- R5: The bad-battery fault ends by itself once `bat_low_i` is 0. Normal charge then resumes with the timer restarted from zero, so a full CYCLE_TICKS ticks are needed to finish.
- R6: A temperature fault is set by `temp_hot_i` or `temp_cold_i`. It stays set until `temp_ok_i` is 1 while both of those flags are 0. While it is active during charging or standby, the outputs are `chg_en_o`=0, `chrg_low_o`=1, `fault_low_o`=1 and `ss_dis_o`=1.
- R7: During a temperature fault the timer count is held. When the fault clears, charging resumes and counting continues from the held value.
- R8: In timer mode, once the count reaches CYCLE_TICKS, charging ends and all four outputs are 0. The block stays finished until shutdown is cycled, or until `bat_low_i` rises, which starts a new cycle in precondition.
- R9: In C/10 mode (`timer_mode_i`=0), the bad-battery fault is never entered, however long `bat_low_i` stays 1. When `c10_low_i` is 1 during charging, the block enters standby with all outputs 0.
- R10: A standby entered while `die_hot_i` was 1 ends when `die_hot_i` falls. A standby entered with `die_hot_i`=0 ends only when `bat_low_i` rises.
- R11: A temperature fault takes priority over the bad-battery check. An under-voltage cell past the one-eighth point shows temperature-fault outputs while the fault is active. The timer stays held during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer enable tick, one count per clock it is high |
| shdn_i | input | 1 | Shutdown request |
| timer_mode_i | input | 1 | 1 = timer termination, 0 = C/10 termination |
| bat_low_i | input | 1 | Battery below precondition threshold |
| temp_hot_i | input | 1 | Cell too hot (fault set) |
| temp_cold_i | input | 1 | Cell too cold (fault set) |
| temp_ok_i | input | 1 | Cell back inside window (fault release) |
| c10_low_i | input | 1 | Charge current below C/10 |
| die_hot_i | input | 1 | Die over-temperature |
| chg_en_o | output | 1 | Charge enable for the power stage |
| chrg_low_o | output | 1 | 1 = drive the charging status pin low, 0 = release |
| fault_low_o | output | 1 | 1 = drive the fault status pin low, 0 = release |
| ss_dis_o | output | 1 | Soft-start capacitor discharge request |

## Verification
The bench builds the block with CYCLE_TICKS=64, which puts the one-eighth point at 8 ticks. With that setting, the bad-battery check and cycle completion can each be reached exactly with a few dozen explicit ticks. Exact tick counts place the checks one tick below and at the one-eighth point, and one tick below and at the full count. They also show that a temperature fault holds the count rather than clearing it, because completion arrives only after the pre-fault and post-fault ticks add up to 64.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_PRE  = 3'd1,
    ST_CHG  = 3'd2,
    ST_STBY = 3'd3,
    ST_DONE = 3'd4,
    ST_BAD  = 3'd5,
    ST_TEMP = 3'd6
  } chg_state_e;
endpackage

// File: rtl/chg_cycle_timer.sv
module chg_cycle_timer #(
  parameter int unsigned CYCLE_TICKS = 4096,
  localparam int unsigned TW = $clog2(CYCLE_TICKS + 1),
  localparam int unsigned EIGHTH = CYCLE_TICKS >> 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          clr_i,
  output logic [TW-1:0] cnt_o,
  output logic          eighth_o,
  output logic          full_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 cnt_q <= '0;
    else if (clr_i)                              cnt_q <= '0;
    else if (run_i && tick_i && !full_o)         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign eighth_o = (cnt_q >= TW'(EIGHTH));
  assign full_o   = (cnt_q >= TW'(CYCLE_TICKS));

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TW'(CYCLE_TICKS));

  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_q) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/chg_temp_latch.sv
module chg_temp_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_i,
  input  logic cold_i,
  input  logic ok_i,
  output logic flt_o
);
  logic flt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             flt_q <= 1'b0;
    else if (hot_i || cold_i) flt_q <= 1'b1;
    else if (ok_i)           flt_q <= 1'b0;
  end

  assign flt_o = flt_q;

  p_temp_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_q && !ok_i) |=> flt_q);
endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
  import chg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       shdn_i,
  input  logic       timer_mode_i,
  input  logic       bat_low_i,
  input  logic       temp_flt_i,
  input  logic       c10_low_i,
  input  logic       die_hot_i,
  input  logic       eighth_i,
  input  logic       full_i,
  output chg_state_e st_o
);
  chg_state_e st_q, st_d;
  logic       stby_therm_q, stby_therm_d;
  chg_state_e resume_st;

  assign resume_st = bat_low_i ? ST_PRE : ST_CHG;

  always_comb begin
    st_d         = st_q;
    stby_therm_d = stby_therm_q;
    if (shdn_i) st_d = ST_OFF;
    else begin
      unique case (st_q)
        ST_OFF: st_d = resume_st;
        ST_PRE, ST_CHG: begin
          if (temp_flt_i) st_d = ST_TEMP;
          else if (timer_mode_i) begin
            if (bat_low_i && eighth_i) st_d = ST_BAD;
            else if (full_i)           st_d = ST_DONE;
            else                       st_d = resume_st;
          end else if (c10_low_i) begin
            st_d         = ST_STBY;
            stby_therm_d = die_hot_i;
          end else st_d = resume_st;
        end
        ST_STBY: begin
          if (temp_flt_i)                         st_d = ST_TEMP;
          else if (stby_therm_q ? !die_hot_i : bat_low_i) st_d = resume_st;
        end
        ST_TEMP: if (!temp_flt_i) st_d = resume_st;
        ST_BAD:  if (!bat_low_i)  st_d = ST_CHG;
        ST_DONE: if (bat_low_i)   st_d = ST_PRE;
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_OFF;
      stby_therm_q <= 1'b0;
    end else begin
      st_q         <= st_d;
      stby_therm_q <= stby_therm_d;
    end
  end

  assign st_o = st_q;

  p_shdn_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_i |=> st_q == ST_OFF);

  p_no_bad_c10_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!timer_mode_i && st_q != ST_BAD) |=> st_q != ST_BAD);
endmodule

// File: rtl/chg_status_drv.sv
module chg_status_drv
  import chg_pkg::*;
(
  input  chg_state_e st_i,
  output logic       chg_en_o,
  output logic       chrg_low_o,
  output logic       fault_low_o,
  output logic       ss_dis_o
);
  always_comb begin
    {chg_en_o, chrg_low_o, fault_low_o, ss_dis_o} = 4'b0000;
    unique case (st_i)
      ST_PRE, ST_CHG: {chg_en_o, chrg_low_o} = 2'b11;
      ST_BAD:         {fault_low_o, ss_dis_o} = 2'b11;
      ST_TEMP:        {chrg_low_o, fault_low_o, ss_dis_o} = 3'b111;
      default:        ;
    endcase
  end

  always_comb begin
    a_en_no_fault_r4: assert (!(chg_en_o && fault_low_o));
  end
endmodule

// File: rtl/chg_timer_ctrl.sv
module chg_timer_ctrl
  import chg_pkg::*;
#(
  parameter int unsigned CYCLE_TICKS = 4096,
  localparam int unsigned TW = $clog2(CYCLE_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic shdn_i,
  input  logic timer_mode_i,
  input  logic bat_low_i,
  input  logic temp_hot_i,
  input  logic temp_cold_i,
  input  logic temp_ok_i,
  input  logic c10_low_i,
  input  logic die_hot_i,
  output logic chg_en_o,
  output logic chrg_low_o,
  output logic fault_low_o,
  output logic ss_dis_o
);
  chg_state_e    st;
  logic [TW-1:0] cnt;
  logic          eighth, full, temp_flt, run, clr;

  assign run = timer_mode_i && (st == ST_PRE || st == ST_CHG);
  assign clr = shdn_i || st == ST_OFF || st == ST_BAD || st == ST_DONE;

  chg_cycle_timer #(.CYCLE_TICKS(CYCLE_TICKS)) i_timer (
    .clk_i, .rst_ni, .tick_i, .run_i(run), .clr_i(clr),
    .cnt_o(cnt), .eighth_o(eighth), .full_o(full)
  );

  chg_temp_latch i_temp (
    .clk_i, .rst_ni, .hot_i(temp_hot_i), .cold_i(temp_cold_i),
    .ok_i(temp_ok_i), .flt_o(temp_flt)
  );

  chg_fsm i_fsm (
    .clk_i, .rst_ni, .shdn_i, .timer_mode_i, .bat_low_i,
    .temp_flt_i(temp_flt), .c10_low_i, .die_hot_i,
    .eighth_i(eighth), .full_i(full), .st_o(st)
  );

  chg_status_drv i_stat (
    .st_i(st), .chg_en_o, .chrg_low_o, .fault_low_o, .ss_dis_o
  );

  p_temp_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == ST_TEMP |=> $stable(cnt));

  p_bad_cnt_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_BAD && $past(st) == ST_BAD) |-> cnt == '0);
endmodule

// File: tb/test_chg_timer_ctrl.sv
module test_chg_timer_ctrl;
  localparam int unsigned CYC = 64;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic shdn_i = 1'b1, timer_mode_i = 1'b1, bat_low_i = 1'b0;
  logic temp_hot_i = 1'b0, temp_cold_i = 1'b0, temp_ok_i = 1'b0;
  logic c10_low_i = 1'b0, die_hot_i = 1'b0;
  logic chg_en_o, chrg_low_o, fault_low_o, ss_dis_o;

  int n_chk = 0, n_bad = 0, cyc_cnt = 0;

  always #2 clk_i = ~clk_i;

  chg_timer_ctrl #(.CYCLE_TICKS(CYC)) i_chg_timer_ctrl (.*);

  // {req, shdn mode bat hot cold ok c10 die, ticks, en chrg flt ss}
  localparam int NV = 34;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1,  8'b11000000, 8'd0,   4'b0000}, // R1 shutdown
    {4'd2,  8'b01100000, 8'd7,   4'b1100}, // R2 below checkpoint
    {4'd2,  8'b01100000, 8'd1,   4'b0011}, // R2 checkpoint reached
    {4'd4,  8'b01100000, 8'd20,  4'b0011}, // R4 fault persists
    {4'd5,  8'b01000000, 8'd0,   4'b1100}, // R5 auto restart
    {4'd5,  8'b01000000, 8'd63,  4'b1100}, // R5 fresh cycle
    {4'd8,  8'b01000000, 8'd1,   4'b0000}, // R8 cycle complete
    {4'd8,  8'b01100000, 8'd0,   4'b1100}, // R8 recharge on bat low
    {4'd3,  8'b01000000, 8'd4,   4'b1100}, // R3
    {4'd3,  8'b01100000, 8'd0,   4'b1100}, // R3 early drop -> precondition
    {4'd3,  8'b01000000, 8'd10,  4'b1100}, // R3
    {4'd3,  8'b01100000, 8'd0,   4'b0011}, // R3 late drop -> bad battery
    {4'd7,  8'b01000000, 8'd30,  4'b1100}, // R7
    {4'd7,  8'b01010000, 8'd50,  4'b0111}, // R7 hot, timer held
    {4'd6,  8'b01000000, 8'd0,   4'b0111}, // R6 latched until release
    {4'd7,  8'b01000100, 8'd33,  4'b1100}, // R7 resumes at 63
    {4'd7,  8'b01000100, 8'd1,   4'b0000}, // R7 completes at 64
    {4'd1,  8'b11000000, 8'd0,   4'b0000}, // R1
    {4'd1,  8'b01000000, 8'd63,  4'b1100}, // R1 new cycle from zero
    {4'd1,  8'b01000000, 8'd1,   4'b0000}, // R1
    {4'd1,  8'b11000000, 8'd0,   4'b0000}, // R1
    {4'd11, 8'b01100000, 8'd5,   4'b1100}, // R11
    {4'd11, 8'b01101000, 8'd20,  4'b0111}, // R11 cold beats bad battery
    {4'd11, 8'b01100100, 8'd0,   4'b1100}, // R11 back to precondition
    {4'd11, 8'b01100100, 8'd3,   4'b0011}, // R11 held count + 3 = 8
    {4'd1,  8'b10000000, 8'd0,   4'b0000}, // R1
    {4'd9,  8'b00100000, 8'd100, 4'b1100}, // R9 no bad battery in C/10
    {4'd9,  8'b00000010, 8'd0,   4'b0000}, // R9 standby
    {4'd10, 8'b00000000, 8'd0,   4'b0000}, // R10 plain standby holds
    {4'd10, 8'b00100000, 8'd0,   4'b1100}, // R10 bat low restarts
    {4'd10, 8'b00000000, 8'd0,   4'b1100}, // R10
    {4'd10, 8'b00000011, 8'd0,   4'b0000}, // R10 thermal standby
    {4'd10, 8'b00000001, 8'd0,   4'b0000}, // R10 still over-temperature
    {4'd10, 8'b00000000, 8'd0,   4'b1100}  // R10 resumes
  };

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic check(input int req, input logic [3:0] exp);
    logic [3:0] act;
    act = {chg_en_o, chrg_low_o, fault_low_o, ss_dis_o};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: outputs act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 100000) begin
      n_bad++;
      $display("FAIL watchdog: act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    bat_low_i = 1'b1;
    shdn_i = 1'b0;
    clocks(3);
    check(1, 4'b0000); // R1 reset state
    rst_ni = 1'b1;
    clocks(3);
    check(2, 4'b1100); // R2 precondition after reset
    shdn_i = 1'b1;
    clocks(2);
    check(1, 4'b0000); // R1

    for (int v = 0; v < NV; v++) begin
      {shdn_i, timer_mode_i, bat_low_i, temp_hot_i, temp_cold_i,
       temp_ok_i, c10_low_i, die_hot_i} = VEC[v][19:12];
      clocks(2);
      for (int t = 0; t < int'(VEC[v][11:4]); t++) begin
        tick_i = 1'b1;
        clocks(1);
        tick_i = 1'b0;
      end
      clocks(2);
      check(int'(VEC[v][23:20]), VEC[v][3:0]);
    end

    // R9: timer-mode C/10 flag has no effect on a timer cycle
    shdn_i = 1'b1; clocks(2);
    shdn_i = 1'b0; timer_mode_i = 1'b1; bat_low_i = 1'b0; c10_low_i = 1'b1;
    clocks(4);
    check(9, 4'b1100);
    c10_low_i = 1'b0;

    // R1: reset mid-fault returns to idle outputs
    bat_low_i = 1'b1;
    for (int t = 0; t < 8; t++) begin tick_i = 1'b1; clocks(1); tick_i = 1'b0; end
    clocks(2);
    check(2, 4'b0011);
    rst_ni = 1'b0; clocks(1);
    check(1, 4'b0000);
    finish_run();
  end
endmodule